// File: doc/BRIEF.md
# Card Buffer DMA Engine

This block sits inside a memory-card host and moves 32-bit words between the host's card data buffer and system memory, so that software does not have to copy block data by programmed I/O. Software picks a direction and an address mode, loads a 64-bit memory address as two 32-bit halves, and writes the start bit. The engine then moves exactly the number of bytes that the block size times the block count gives. That length is computed elsewhere and arrives on `xfer_len`.

The card buffer side is two ready/valid word streams: one carries words out of the card buffer and one carries words into it. Memory is a single word port. A request is accepted in the cycle `mem_gnt` is high, and in that same cycle read data and an error indication come back. Each direction has its own completion flag and its own error flag. Each flag has a mask bit, and any flag that is set and not masked raises `irq`. DMA runs only while the host's global DMA-enable mode (`dma_en`) is on, and only from a memory address aligned to 16 bytes.

Top module: `card_dma`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `irq` is 0, and no memory, card-read or card-write handshake signal is asserted.
- R2: Writing 1 to bit 0 of register index 1 (start) launches a transfer. Reading that register returns 1 while a transfer is active and 0 once it has ended, so the bit clears itself. A start written while a transfer is active is ignored.
- R3: In direction card-to-memory (bit 0 of the mode register, index 0, set to 1), each word taken from the card stream is written to memory in arrival order. With increment mode on (mode bit 1 = 1), word i goes to base + 4·i.
- R4: With increment mode off (mode bit 1 = 0), every memory access of the transfer uses the base address.
- R5: In direction memory-to-card (mode bit 0 = 0), words read from memory are presented on the card-write stream in address order.
- R6: A transfer moves exactly `xfer_len`/4 words. When the last word is accepted it sets the completion flag of its direction (register index 3: bit 0 for memory-to-card, bit 1 for card-to-memory). With no back-pressure, N words take 2·N cycles from the start write to the flag. A length of 0 sets the flag on the start write and makes no access.
- R7: A start with address bits [3:0] not all zero makes no memory or card access. It sets the error flag of the selected direction (register index 5: bit 0 for memory-to-card, bit 1 for card-to-memory).
- R8: While `dma_en` is 0, a start write has no effect. No transfer begins, no flag is set and no access is made.
- R9: When `mem_err` is high in a granted memory cycle, that access is dropped. The error flag of the active direction is set, the transfer ends, and no completion flag is set.
- R10: A write to the completion register (index 3) or the error register (index 5) ANDs the flags with the written bits. Writing 0 clears a flag and writing 1 leaves it unchanged.
- R11: `irq` is high exactly when some completion or error flag is set and its mask bit is 0. The masks are register index 4 for completion and index 6 for error, with bits placed as in the flag registers.
- R12: Writing 1 to a bit of the channel-reset register (index 2; bit 0 memory-to-card, bit 1 card-to-memory) aborts a transfer running in that direction and clears that direction's completion and error flags. Flags of the other direction are kept.
- R13: Register index 7 holds address bits [31:0] and index 8 holds bits [63:32]. Both read back as written, and together they form the full 64-bit `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| dma_en | input | 1 | Global DMA-enable mode of the host |
| xfer_len | input | LEN_W | Transfer length in bytes, a multiple of 4 |
| cbuf_rvalid | input | 1 | Card buffer offers a word |
| cbuf_rdata | input | DATA_W | Word from the card buffer |
| cbuf_rready | output | 1 | Engine takes the offered card word |
| cbuf_wvalid | output | 1 | Engine offers a word to the card buffer |
| cbuf_wdata | output | DATA_W | Word for the card buffer |
| cbuf_wready | input | 1 | Card buffer takes the word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the access |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the grant cycle |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_err | input | 1 | Memory reports a fault for the granted access |
| irq | output | 1 | Any unmasked flag set |

## Verification
Register writes take effect at the clock edge that samples the strobe. The start write moves the engine out of idle on that same edge. With no stalls, each word then spends one cycle fetching and one cycle storing, so the completion flag and `irq` appear on the 2·N-th edge after the start edge. The latency test samples the flag one cycle before that edge and again right after it. Errors from misalignment and from a channel reset show up on the edge that takes the write. The bench therefore reads them one cycle later. Transfers that run under back-pressure are instead followed by polling the self-clearing start bit, and the memory and card models are checked only after the engine reports idle.

// File: rtl/card_dma_pkg.sv
// Shared constants and types of the card buffer DMA engine.
package card_dma_pkg;
    localparam int REG_W  = 32;
    localparam int MEM_AW = 64;
    localparam int IDX_W  = 4;

    // register word indices
    localparam logic [IDX_W-1:0] RI_MODE     = 4'd0;
    localparam logic [IDX_W-1:0] RI_START    = 4'd1;
    localparam logic [IDX_W-1:0] RI_CHRST    = 4'd2;
    localparam logic [IDX_W-1:0] RI_DONE     = 4'd3;
    localparam logic [IDX_W-1:0] RI_DONE_MSK = 4'd4;
    localparam logic [IDX_W-1:0] RI_ERR      = 4'd5;
    localparam logic [IDX_W-1:0] RI_ERR_MSK  = 4'd6;
    localparam logic [IDX_W-1:0] RI_ADDR_LO  = 4'd7;
    localparam logic [IDX_W-1:0] RI_ADDR_HI  = 4'd8;

    // mode bits; flag bit index equals direction value
    localparam int MODE_DIR_BIT = 0;  // 1 = card to memory
    localparam int MODE_INC_BIT = 1;  // 1 = address increments

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GET  = 2'd1,
        ST_PUT  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/card_dma_regs.sv
// Register file of the DMA engine: mode, 64-bit base address, masks and
// per-direction completion/error flags. Assumes reg_idx is stable while
// reg_we is high; start and channel reset are decoded straight from the write.
module card_dma_regs
    import card_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy_i,
    input  logic [1:0]       done_set_i,
    input  logic [1:0]       err_set_i,
    output logic             start_o,
    output logic [1:0]       chan_rst_o,
    output logic             dir_o,
    output logic             incr_o,
    output logic [MEM_AW-1:0] base_addr_o,
    output logic             irq_o
);
    logic             dir_q, incr_q;
    logic [1:0]       done_q, err_q, done_msk_q, err_msk_q;
    logic [REG_W-1:0] lo_q, hi_q;
    logic             wr_done, wr_err;

    assign wr_done    = reg_we && (reg_idx == RI_DONE);
    assign wr_err     = reg_we && (reg_idx == RI_ERR);
    assign start_o    = reg_we && (reg_idx == RI_START) && reg_wdata[0];
    assign chan_rst_o = (reg_we && (reg_idx == RI_CHRST)) ? reg_wdata[1:0] : 2'b00;

    // Plain configuration registers, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0; incr_q <= 1'b0;
            done_msk_q <= 2'b00; err_msk_q <= 2'b00;
            lo_q <= '0; hi_q <= '0;
        end else if (reg_we) begin
            unique case (reg_idx)
                RI_MODE: begin
                    dir_q  <= reg_wdata[MODE_DIR_BIT];
                    incr_q <= reg_wdata[MODE_INC_BIT];
                end
                RI_DONE_MSK: done_msk_q <= reg_wdata[1:0];
                RI_ERR_MSK:  err_msk_q  <= reg_wdata[1:0];
                RI_ADDR_LO:  lo_q <= reg_wdata;
                RI_ADDR_HI:  hi_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // One flag pair per direction: set by the engine, AND-cleared by software,
    // wiped by the channel reset of that direction.
    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic done_b, err_b;
        always_ff @(posedge clk) begin
            if (!rst_n || chan_rst_o[d]) begin
                done_b <= 1'b0;
                err_b  <= 1'b0;
            end else begin
                done_b <= done_set_i[d] | (done_b & ~(wr_done & ~reg_wdata[d]));
                err_b  <= err_set_i[d]  | (err_b  & ~(wr_err  & ~reg_wdata[d]));
            end
        end
        assign done_q[d] = done_b;
        assign err_q[d]  = err_b;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            RI_MODE:     begin
                reg_rdata[MODE_DIR_BIT] = dir_q;
                reg_rdata[MODE_INC_BIT] = incr_q;
            end
            RI_START:    reg_rdata[0]   = busy_i;
            RI_DONE:     reg_rdata[1:0] = done_q;
            RI_DONE_MSK: reg_rdata[1:0] = done_msk_q;
            RI_ERR:      reg_rdata[1:0] = err_q;
            RI_ERR_MSK:  reg_rdata[1:0] = err_msk_q;
            RI_ADDR_LO:  reg_rdata = lo_q;
            RI_ADDR_HI:  reg_rdata = hi_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign dir_o       = dir_q;
    assign incr_o      = incr_q;
    assign base_addr_o = {hi_q, lo_q};
    assign irq_o       = |(done_q & ~done_msk_q) | |(err_q & ~err_msk_q);

    a_r10_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && reg_wdata[1:0] == 2'b00 && done_set_i == 2'b00) |=> (done_q == 2'b00));
    a_r12_chan_clear: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst_o[1] |=> (!done_q[1] && !err_q[1]));
endmodule

// File: rtl/card_dma_engine.sv
// Transfer engine: a two-phase loop (fetch a word, store it) driven by the
// latched direction. Assumes the memory returns read data and fault in the
// grant cycle and that xfer_len is a multiple of the word size.
module card_dma_engine
    import card_dma_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 20,
    parameter int ALIGN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        chan_rst_i,
    input  logic              dma_en_i,
    input  logic [LEN_W-1:0]  xfer_len_i,
    input  logic              dir_i,
    input  logic              incr_i,
    input  logic [MEM_AW-1:0] base_addr_i,
    input  logic              cbuf_rvalid_i,
    input  logic [DATA_W-1:0] cbuf_rdata_i,
    output logic              cbuf_rready_o,
    output logic              cbuf_wvalid_o,
    output logic [DATA_W-1:0] cbuf_wdata_o,
    input  logic              cbuf_wready_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_gnt_i,
    input  logic              mem_err_i,
    output logic              busy_o,
    output logic [1:0]        done_set_o,
    output logic [1:0]        err_set_o
);
    localparam int STEP      = DATA_W / 8;
    localparam int BYTE_LSB  = $clog2(STEP);
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);
    localparam int CNT_W     = LEN_W - BYTE_LSB;

    eng_state_t        state_q;
    logic              dir_q, incr_q;
    logic [MEM_AW-1:0] cur_addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [DATA_W-1:0] hold_q;

    logic [CNT_W-1:0] words;
    logic misaligned, accept, launch, get_fire, put_fire, mem_fault, abort, last;

    assign words      = xfer_len_i[LEN_W-1:BYTE_LSB];
    assign misaligned = |base_addr_i[ALIGN_LSB-1:0];
    assign accept     = start_i && dma_en_i && (state_q == ST_IDLE);
    assign launch     = accept && !misaligned && (words != '0);
    assign get_fire   = (state_q == ST_GET) && (dir_q ? cbuf_rvalid_i : mem_gnt_i);
    assign put_fire   = (state_q == ST_PUT) && (dir_q ? mem_gnt_i : cbuf_wready_i);
    assign mem_fault  = mem_req_o && mem_gnt_i && mem_err_i;
    assign abort      = (state_q != ST_IDLE) && chan_rst_i[dir_q];
    assign last       = (left_q == CNT_W'(1));

    // Handshake outputs follow the phase and the latched direction.
    assign cbuf_rready_o = (state_q == ST_GET) && dir_q;
    assign cbuf_wvalid_o = (state_q == ST_PUT) && !dir_q;
    assign mem_req_o     = ((state_q == ST_GET) && !dir_q) || ((state_q == ST_PUT) && dir_q);
    assign mem_we_o      = (state_q == ST_PUT) && dir_q;
    assign mem_addr_o    = cur_addr_q;
    assign mem_wdata_o   = hold_q;
    assign cbuf_wdata_o  = hold_q;
    assign busy_o        = (state_q != ST_IDLE);

    // Flag set pulses: start-time checks, memory faults and final word.
    always_comb begin
        done_set_o = 2'b00;
        err_set_o  = 2'b00;
        if (accept) begin
            if (misaligned)        err_set_o[dir_i]  = 1'b1;
            else if (words == '0)  done_set_o[dir_i] = 1'b1;
        end else if (!abort) begin
            if (mem_fault)             err_set_o[dir_q]  = 1'b1;
            else if (put_fire && last) done_set_o[dir_q] = 1'b1;
        end
    end

    // Phase sequencer with address and word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            dir_q      <= 1'b0;
            incr_q     <= 1'b0;
            cur_addr_q <= '0;
            left_q     <= '0;
            hold_q     <= '0;
        end else if (abort || mem_fault) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    dir_q      <= dir_i;
                    incr_q     <= incr_i;
                    cur_addr_q <= base_addr_i;
                    left_q     <= words;
                    state_q    <= ST_GET;
                end
                ST_GET: if (get_fire) begin
                    hold_q  <= dir_q ? cbuf_rdata_i : mem_rdata_i;
                    state_q <= ST_PUT;
                end
                ST_PUT: if (put_fire) begin
                    left_q <= left_q - 1'b1;
                    if (incr_q) cur_addr_q <= cur_addr_q + MEM_AW'(STEP);
                    state_q <= last ? ST_IDLE : ST_GET;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r7_unaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && misaligned) |=> (state_q == ST_IDLE && !mem_req_o));
    a_r4_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !incr_q) |=> (mem_addr_o == $past(mem_addr_o)));
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (put_fire && !abort && !mem_fault && !last) |=> (left_q == $past(left_q) - 1'b1));
    a_r9_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fault |=> (state_q == ST_IDLE));
    a_r3_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_o, cbuf_rready_o, cbuf_wvalid_o}));
endmodule

// File: rtl/card_dma.sv
// Top of the card buffer DMA engine: register file plus transfer engine.
// Assumes a single clock domain and a 32-bit register port.
module card_dma
    import card_dma_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 20,
    parameter int ALIGN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dma_en,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              cbuf_rvalid,
    input  logic [DATA_W-1:0] cbuf_rdata,
    output logic              cbuf_rready,
    output logic              cbuf_wvalid,
    output logic [DATA_W-1:0] cbuf_wdata,
    input  logic              cbuf_wready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [63:0]       mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    input  logic              mem_err,
    output logic              irq
);
    logic              start, busy, dir, incr;
    logic [1:0]        chan_rst, done_set, err_set;
    logic [MEM_AW-1:0] base_addr;

    card_dma_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy_i(busy), .done_set_i(done_set), .err_set_i(err_set),
        .start_o(start), .chan_rst_o(chan_rst), .dir_o(dir), .incr_o(incr),
        .base_addr_o(base_addr), .irq_o(irq)
    );

    card_dma_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W), .ALIGN_BYTES(ALIGN_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .chan_rst_i(chan_rst), .dma_en_i(dma_en), .xfer_len_i(xfer_len),
        .dir_i(dir), .incr_i(incr), .base_addr_i(base_addr),
        .cbuf_rvalid_i(cbuf_rvalid), .cbuf_rdata_i(cbuf_rdata), .cbuf_rready_o(cbuf_rready),
        .cbuf_wvalid_o(cbuf_wvalid), .cbuf_wdata_o(cbuf_wdata), .cbuf_wready_i(cbuf_wready),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .mem_gnt_i(mem_gnt), .mem_err_i(mem_err),
        .busy_o(busy), .done_set_o(done_set), .err_set_o(err_set)
    );
endmodule

// File: tb/card_dma_bench.sv
module card_dma_bench;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              reg_we = 1'b0;
    logic [3:0]        reg_idx = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              dma_en = 1'b1;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic              cbuf_rvalid, cbuf_rready, cbuf_wvalid, cbuf_wready;
    logic [DATA_W-1:0] cbuf_rdata, cbuf_wdata, mem_wdata, mem_rdata;
    logic              mem_req, mem_we, mem_gnt, mem_err, irq;
    logic [63:0]       mem_addr;

    card_dma #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_card_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_en(dma_en), .xfer_len(xfer_len),
        .cbuf_rvalid(cbuf_rvalid), .cbuf_rdata(cbuf_rdata), .cbuf_rready(cbuf_rready),
        .cbuf_wvalid(cbuf_wvalid), .cbuf_wdata(cbuf_wdata), .cbuf_wready(cbuf_wready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .mem_err(mem_err), .irq(irq)
    );

    // ---------------- memory and card models ----------------
    function automatic logic [31:0] card_pat(int i);
        return 32'hCA5E_0000 + 32'(i) * 32'h0000_0101;
    endfunction
    function automatic logic [31:0] init_pat(int i);
        return 32'h6000_0000 + 32'(i) * 32'h0001_0003;
    endfunction

    logic [31:0] mem [64];
    logic [31:0] sink [64];
    logic [31:0] cyc = '0;
    int          src_idx = 0, sink_cnt = 0, req_cnt = 0;
    logic [31:0] hi_seen = '0;
    logic        model_clr = 1'b0, stall_en = 1'b0, inj_en = 1'b0;
    logic [7:0]  inj_addr = '0;
    logic        hs;

    assign hs          = stall_en ? cyc[0] : 1'b1;
    assign cbuf_rvalid = hs;
    assign cbuf_rdata  = card_pat(src_idx);
    assign cbuf_wready = hs;
    assign mem_gnt     = hs;
    assign mem_rdata   = mem[mem_addr[7:2]];
    assign mem_err     = inj_en && (mem_addr[7:0] == inj_addr);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (model_clr) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_pat(i);
            src_idx <= 0; sink_cnt <= 0; req_cnt <= 0;
        end else begin
            if (mem_req && mem_gnt && mem_we && !mem_err) mem[mem_addr[7:2]] <= mem_wdata;
            if (cbuf_rvalid && cbuf_rready) src_idx <= src_idx + 1;
            if (cbuf_wvalid && cbuf_wready) begin
                sink[sink_cnt[5:0]] <= cbuf_wdata;
                sink_cnt <= sink_cnt + 1;
            end
            if (mem_req) begin
                req_cnt <= req_cnt + 1;
                hi_seen <= mem_addr[63:32];
            end
        end
    end

    // ---------------- check helpers ----------------
    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #1;
        d = reg_rdata;
    endtask

    task automatic clr_model();
        @(negedge clk); model_clr = 1'b1;
        @(negedge clk); model_clr = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        v = 32'd1;
        for (int n = 0; n < 3000; n++) begin
            rd(4'd1, v);
            if (v[0] == 1'b0) break;
            @(negedge clk);
        end
        check("R2 start bit self-clears", 64'(v[0]), 64'd0);
    endtask

    // vector: {dir, incr, stall, addr[7:0], words[5:0]}
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 1'b1, 1'b0, 8'h00, 6'd8},
        {1'b1, 1'b1, 1'b1, 8'h40, 6'd5},
        {1'b1, 1'b0, 1'b0, 8'h80, 6'd4},
        {1'b0, 1'b1, 1'b1, 8'h10, 6'd6},
        {1'b0, 1'b0, 1'b0, 8'h30, 6'd3},
        {1'b0, 1'b1, 1'b0, 8'hC0, 6'd16}
    };

    task automatic run_vec(input logic [16:0] vec);
        logic dir, incr;
        int b, n;
        logic [31:0] v;
        dir = vec[16]; incr = vec[15]; n = int'(vec[5:0]); b = int'(vec[13:6]) >> 2;
        clr_model();
        stall_en = vec[14];
        xfer_len = LEN_W'(n * 4);
        wr(4'd0, {30'd0, incr, dir});
        wr(4'd7, {24'd0, vec[13:6]});
        wr(4'd8, 32'd0);
        wr(4'd1, 32'd1);
        wait_idle();
        rd(4'd3, v); check("R6 done flag of direction", 64'(v), dir ? 64'd2 : 64'd1);
        rd(4'd5, v); check("R6 no error flag", 64'(v), 64'd0);
        if (dir) begin
            if (incr) begin
                for (int i = 0; i < n; i++) check("R3 card word at base+4i", 64'(mem[(b + i) & 63]), 64'(card_pat(i)));
                check("R6 no word past length", 64'(mem[(b + n) & 63]), 64'(init_pat((b + n) & 63)));
            end else begin
                check("R4 fixed address holds last word", 64'(mem[b]), 64'(card_pat(n - 1)));
                check("R4 next address untouched", 64'(mem[b + 1]), 64'(init_pat(b + 1)));
            end
        end else begin
            check("R6 card word count", 64'(sink_cnt), 64'(n));
            for (int i = 0; i < n; i++)
                check(incr ? "R5 memory words in order" : "R4 fixed address reads",
                      64'(sink[i]), 64'(init_pat(incr ? ((b + i) & 63) : b)));
        end
        stall_en = 1'b0;
        wr(4'd3, 32'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 9; i++) begin
            rd(4'(i), v);
            check("R1 register reset value", 64'(v), 64'd0);
        end
        check("R1 irq after reset", 64'(irq), 64'd0);
        check("R1 no handshakes after reset", 64'({mem_req, cbuf_rready, cbuf_wvalid}), 64'd0);

        // table of transfers
        for (int k = 0; k < 6; k++) run_vec(VEC[k]);

        // R6 exact latency, 4 words, no stall
        clr_model();
        xfer_len = LEN_W'(16);
        wr(4'd0, 32'd3); wr(4'd7, 32'd0); wr(4'd8, 32'd0);
        wr(4'd1, 32'd1);
        rd(4'd1, v); check("R2 start reads busy", 64'(v), 64'd1);
        repeat (7) @(negedge clk);
        rd(4'd3, v); check("R6 done not before 2N cycles", 64'(v), 64'd0);
        @(negedge clk);
        rd(4'd3, v); check("R6 done at 2N cycles", 64'(v), 64'd2);
        check("R11 irq on unmasked done", 64'(irq), 64'd1);
        wr(4'd4, 32'd2);
        check("R11 masked done keeps irq low", 64'(irq), 64'd0);
        wr(4'd4, 32'd0);
        wr(4'd3, 32'd0);

        // R2 start while busy ignored
        clr_model();
        stall_en = 1'b1;
        xfer_len = LEN_W'(32);
        wr(4'd0, 32'd3); wr(4'd7, 32'h40);
        wr(4'd1, 32'd1);
        wr(4'd1, 32'd1);
        wait_idle();
        for (int i = 0; i < 8; i++) check("R2 restart ignored, data", 64'(mem[16 + i]), 64'(card_pat(i)));
        check("R2 restart ignored, card pops", 64'(src_idx), 64'd8);
        stall_en = 1'b0;
        wr(4'd3, 32'd0);

        // R6 zero length
        clr_model();
        xfer_len = '0;
        wr(4'd0, 32'd2); wr(4'd7, 32'h20);
        wr(4'd1, 32'd1);
        rd(4'd3, v); check("R6 zero length completes at once", 64'(v), 64'd1);
        check("R6 zero length makes no access", 64'(req_cnt), 64'd0);
        wr(4'd3, 32'd0);

        // R7 unaligned, card to memory
        clr_model();
        xfer_len = LEN_W'(16);
        wr(4'd0, 32'd3); wr(4'd7, 32'h24);
        wr(4'd1, 32'd1);
        @(negedge clk);
        rd(4'd5, v); check("R7 unaligned sets card-to-memory error", 64'(v), 64'd2);
        rd(4'd1, v); check("R7 unaligned does not start", 64'(v), 64'd0);
        rd(4'd3, v); check("R7 unaligned no done", 64'(v), 64'd0);
        check("R7 unaligned no access", 64'({req_cnt[15:0], src_idx[15:0]}), 64'd0);
        check("R7 memory untouched", 64'(mem[9]), 64'(init_pat(9)));
        check("R11 irq on unmasked error", 64'(irq), 64'd1);
        wr(4'd6, 32'd2);
        check("R11 masked error keeps irq low", 64'(irq), 64'd0);
        wr(4'd6, 32'd0);

        // R7 unaligned, memory to card
        wr(4'd0, 32'd2); wr(4'd7, 32'h08);
        wr(4'd1, 32'd1);
        rd(4'd5, v); check("R7 unaligned sets memory-to-card error", 64'(v), 64'd3);
        check("R7 no card write", 64'(sink_cnt), 64'd0);

        // R10 AND-clear
        wr(4'd5, 32'd1);
        rd(4'd5, v); check("R10 write 1 keeps, write 0 clears", 64'(v), 64'd1);

        // R12 channel reset of the card-to-memory direction
        clr_model();
        stall_en = 1'b1;
        xfer_len = LEN_W'(64);
        wr(4'd0, 32'd3); wr(4'd7, 32'h00);
        wr(4'd1, 32'd1);
        repeat (6) @(negedge clk);
        wr(4'd2, 32'd2);
        rd(4'd1, v); check("R12 channel reset aborts", 64'(v), 64'd0);
        rd(4'd3, v); check("R12 no done after abort", 64'(v), 64'd0);
        rd(4'd5, v); check("R12 other direction flag kept", 64'(v), 64'd1);
        repeat (10) @(negedge clk);
        check("R12 no later writes", 64'(mem[15]), 64'(init_pat(15)));
        wr(4'd2, 32'd1);
        rd(4'd5, v); check("R12 own direction flags cleared", 64'(v), 64'd0);
        stall_en = 1'b0;

        // R8 DMA disabled
        clr_model();
        dma_en = 1'b0;
        xfer_len = LEN_W'(16);
        wr(4'd0, 32'd3); wr(4'd7, 32'h00);
        wr(4'd1, 32'd1);
        repeat (5) @(negedge clk);
        rd(4'd1, v); check("R8 disabled start not busy", 64'(v), 64'd0);
        rd(4'd3, v); check("R8 disabled no done", 64'(v), 64'd0);
        rd(4'd5, v); check("R8 disabled no error", 64'(v), 64'd0);
        check("R8 disabled no access", 64'(req_cnt), 64'd0);
        dma_en = 1'b1;

        // R9 memory fault on the third read
        clr_model();
        inj_en = 1'b1; inj_addr = 8'h28;
        xfer_len = LEN_W'(16);
        wr(4'd0, 32'd2); wr(4'd7, 32'h20);
        wr(4'd1, 32'd1);
        wait_idle();
        rd(4'd5, v); check("R9 fault sets memory-to-card error", 64'(v), 64'd1);
        rd(4'd3, v); check("R9 fault no done", 64'(v), 64'd0);
        check("R9 transfer stops at fault", 64'(sink_cnt), 64'd2);
        inj_en = 1'b0;
        wr(4'd5, 32'd0);

        // R13 high address word
        clr_model();
        xfer_len = LEN_W'(4);
        wr(4'd0, 32'd3); wr(4'd7, 32'h10); wr(4'd8, 32'h1234_5678);
        wr(4'd1, 32'd1);
        wait_idle();
        check("R13 high word on mem_addr", 64'(hi_seen), 64'h1234_5678);
        rd(4'd8, v); check("R13 high word reads back", 64'(v), 64'h1234_5678);
        rd(4'd7, v); check("R13 low word reads back", 64'(v), 64'h10);
        check("R13 data stored at low offset", 64'(mem[4]), 64'(card_pat(0)));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule